// File: doc/BRIEF.md
# Double-Buffered Serial DAC Input Register

This block is the digital front end of a 12-bit voltage-output converter. A serial word is shifted in one bit per rising edge of a serial clock, most significant bit first, only while the active-low select is asserted. A separate holding register drives the parallel code to the converter. Bits can therefore be preloaded without disturbing the present output.

The holding register is controlled by an active-low load strobe that works on level, not on an edge. While load is low, the output follows the shift register. When load returns high, the output keeps the value present at that moment. An active-low clear acts asynchronously and forces the output code to zero. Clear takes priority over load, and it leaves the shift register untouched. Select gates only the shift path and never the load path.

The code maps linearly to output voltage at 0.5 mV per LSB. Code FFFh gives 2.0475 V and code 800h gives 1.024 V. All pins are sampled on a faster system clock, which models the serial clock edges and the strobe levels synchronously.

A protocol flag pulses when a serial clock rising edge arrives while select and load are both low.

Top module: `serial_dac_front`

## Requirements
- R1: After rst_ni is released, code_o is 0, viol_o is 0, and the shift register holds 0. A load strobe with no bits shifted gives code_o = 0.
- R2: Each rising edge of sclk_i while sel_ni is low shifts sdata_i into bit 0 of the 12-bit shift register. Existing bits move toward bit 11, so the first bit sent ends up in code_o[11] (MSB first).
- R3: A rising edge of sclk_i while sel_ni is high leaves the shift register unchanged.
- R4: The load strobe acts the same way whether sel_ni is high or low.
- R5: While load_ni is high, code_o does not change, even while new bits are shifted in.
- R6: While load_ni is low and clr_ni is high, code_o follows the shift register one system clock later. When load_ni rises, code_o keeps the value it had at that moment.
- R7: When clr_ni goes low, code_o becomes 0 at once, without waiting for a clock edge.
- R8: While clr_ni and load_ni are both low, code_o stays 0. If clr_ni is released while load_ni is still low, code_o takes the shift register contents.
- R9: Clear does not change the shift register contents.
- R10: viol_o is high for one cycle after any sclk_i rising edge seen while sel_ni and load_ni are both low. It stays low otherwise.
- R11: When more than 12 bits are shifted, only the last 12 bits are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System oversampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_ni | input | 1 | Active-low select; enables shifting |
| sclk_i | input | 1 | Serial clock; shifts on its rising edge |
| sdata_i | input | 1 | Serial data, MSB first |
| load_ni | input | 1 | Active-low, level-sensitive load strobe |
| clr_ni | input | 1 | Asynchronous active-low clear of the output code |
| code_o | output | 12 | Parallel code to the converter |
| viol_o | output | 1 | Pulse flagging a shift while load is low |

## Verification
The bench shifts several words with different bit patterns: a mixed word with an asymmetric MSB/LSB pair, all ones, 800h, and a 16-bit overrun. These show that the bit order and the shift direction are correct and that only the last 12 bits survive.

Further sequences check the following:
- Shifting with select high, and strobing load with select high, separate the gated shift path from the ungated load path.
- Clear pulses placed mid-cycle, and clear overlapping a held-low load, show that clear acts asynchronously, that it takes priority over load, and that the shift contents survive it.
- A bit clocked in while load is held low confirms both transparency and the violation pulse.

// File: rtl/serial_dac_pkg.sv
package serial_dac_pkg;
  parameter int unsigned CODE_W = 12;
  localparam logic [CODE_W-1:0] CODE_ZERO = '0;
endpackage

// File: rtl/sdac_edge_rise.sv
module sdac_edge_rise (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic sig_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end
  assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/sdac_shift_in.sv
module sdac_shift_in #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  input  logic         bit_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] word_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    word_q <= '0;
    else if (adv_i) word_q <= {word_q[W-2:0], bit_i};
  end
  assign word_o = word_q;
endmodule

// File: rtl/sdac_hold_reg.sv
module sdac_hold_reg #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_ni,
  input  logic         load_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;
  // clear and reset both zero the code asynchronously; clear beats load
  always_ff @(posedge clk_i or negedge rst_ni or negedge clr_ni) begin
    if (!rst_ni || !clr_ni) q_q <= '0;
    else if (!load_ni)      q_q <= d_i;
  end
  assign q_o = q_q;
endmodule

// File: rtl/serial_dac_front.sv
module serial_dac_front
  import serial_dac_pkg::*;
#(
  parameter int unsigned W = CODE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sel_ni,
  input  logic         sclk_i,
  input  logic         sdata_i,
  input  logic         load_ni,
  input  logic         clr_ni,
  output logic [W-1:0] code_o,
  output logic         viol_o
);
  logic         sclk_rise;
  logic         shift_adv;
  logic [W-1:0] shift_q;
  logic         viol_q;

  sdac_edge_rise i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (sclk_i),
    .rise_o (sclk_rise)
  );

  assign shift_adv = sclk_rise & ~sel_ni;

  sdac_shift_in #(.W(W)) i_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (shift_adv),
    .bit_i  (sdata_i),
    .word_o (shift_q)
  );

  sdac_hold_reg #(.W(W)) i_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_ni  (clr_ni),
    .load_ni (load_ni),
    .d_i     (shift_q),
    .q_o     (code_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) viol_q <= 1'b0;
    else         viol_q <= shift_adv & ~load_ni;
  end
  assign viol_o = viol_q;
endmodule

// File: rtl/serial_dac_front_chk.sv
module serial_dac_front_chk #(
  parameter int unsigned W = 12
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         sel_ni,
  input logic         load_ni,
  input logic         clr_ni,
  input logic [W-1:0] shift_q,
  input logic [W-1:0] code_o,
  input logic         viol_o
);
  p_sel_block_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_ni |=> $stable(shift_q));

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni || !clr_ni)
    (load_ni && clr_ni) |=> $stable(code_o));

  p_transp_r6: assert property (@(posedge clk_i) disable iff (!rst_ni || !clr_ni)
    (!load_ni && clr_ni) |=> (code_o == $past(shift_q)));

  p_clr_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |-> (code_o == '0));

  p_viol_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> ($past(!sel_ni) && $past(!load_ni)));

  p_viol_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |=> (!viol_o || $past(!load_ni)));
endmodule

bind serial_dac_front serial_dac_front_chk #(.W(W)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sel_ni  (sel_ni),
  .load_ni (load_ni),
  .clr_ni  (clr_ni),
  .shift_q (shift_q),
  .code_o  (code_o),
  .viol_o  (viol_o)
);

// File: tb/test_serial_dac_front.sv
module test_serial_dac_front;
  localparam int CLK_PERIOD = 10;
  localparam int W = 12;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic sel_ni = 1'b1, sclk_i = 1'b0, sdata_i = 1'b0, load_ni = 1'b1, clr_ni = 1'b1;
  logic [W-1:0] code_o;
  logic viol_o;
  int checks = 0, errors = 0;
  bit viol_seen = 0;
  bit done = 0;

  serial_dac_front i_serial_dac_front (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_ni(sel_ni), .sclk_i(sclk_i),
    .sdata_i(sdata_i), .load_ni(load_ni), .clr_ni(clr_ni),
    .code_o(code_o), .viol_o(viol_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  always @(negedge clk_i) if (viol_o) viol_seen = 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic send_bits(input logic [31:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdata_i = w[i]; sclk_i = 1'b0; idle(1);
      sclk_i = 1'b1; idle(1);
      sclk_i = 1'b0;
    end
    idle(1);
  endtask

  task automatic pulse_load();
    load_ni = 1'b0; idle(2);
    load_ni = 1'b1; idle(2);
  endtask

  task automatic t_reset();
    chk("R1 code after reset", code_o, 0);
    chk("R1 viol after reset", viol_o, 0);
    pulse_load();
    chk("R1 empty shift register loads zero", code_o, 0);
  endtask

  task automatic t_shift_load();
    sel_ni = 1'b0; viol_seen = 0;
    send_bits(32'hA51, W);
    chk("R5 code held while shifting", code_o, 0);
    chk("R10 no flag with load high", viol_seen, 0);
    pulse_load();
    chk("R2 MSB-first word", code_o, 32'hA51);
    send_bits(32'hFFF, W);
    chk("R5 code held at old word", code_o, 32'hA51);
    pulse_load();
    chk("R2 full scale word", code_o, 32'hFFF);
    send_bits(32'h800, W);
    pulse_load();
    chk("R2 mid scale word", code_o, 32'h800);
  endtask

  task automatic t_select();
    sel_ni = 1'b1;
    send_bits(32'h3C3, W);
    pulse_load();
    chk("R3 shifting ignored while deselected; R4 load still works", code_o, 32'h800);
    sel_ni = 1'b0;
    send_bits(32'h123, W);
    sel_ni = 1'b1;
    pulse_load();
    chk("R4 load with select high", code_o, 32'h123);
  endtask

  task automatic t_clear();
    @(posedge clk_i); #2 clr_ni = 1'b0; #1;
    chk("R7 asynchronous clear", code_o, 0);
    idle(2);
    clr_ni = 1'b1; idle(2);
    chk("R7 cleared code stays zero", code_o, 0);
    pulse_load();
    chk("R9 shift register survives clear", code_o, 32'h123);
    load_ni = 1'b0; clr_ni = 1'b0; idle(3);
    chk("R8 clear wins over load", code_o, 0);
    clr_ni = 1'b1; idle(2);
    chk("R8 transparent after clear release", code_o, 32'h123);
    load_ni = 1'b1; idle(1);
  endtask

  task automatic t_transparent();
    sel_ni = 1'b0; load_ni = 1'b0; viol_seen = 0;
    send_bits(32'h1, 1);
    chk("R6 code follows shift register", code_o, 32'h247);
    chk("R10 flag on shift while load low", viol_seen, 1);
    load_ni = 1'b1; idle(1);
    viol_seen = 0;
    send_bits(32'h0, 1);
    chk("R6 latched at load release", code_o, 32'h247);
    chk("R10 no flag once load high", viol_seen, 0);
  endtask

  task automatic t_overrun();
    sel_ni = 1'b0;
    send_bits(32'hBEEF, 16);
    pulse_load();
    chk("R11 only last 12 bits kept", code_o, 32'hEEF);
  endtask

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(2);
    t_reset();
    t_shift_load();
    t_select();
    t_clear();
    t_transparent();
    t_overrun();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule